// File: doc/BRIEF.md
# Multi-Channel Oscillator Event Timestamper

This block watches a set of free-running oscillator lines that are unrelated to its own clock. Each line feeds its own prescaler, so that a fast oscillator produces a slow, regular stream of events. The nominal ratio is ten million, which gives one event per second from a 10 MHz unit. Every event crosses into the reference clock domain. There it is stamped with the value of one shared time base. The time base counts in packed BCD, so that printing the stamp later only needs a fixed high nibble added to each digit.

All channels whose events reach the reference domain in the same cycle are merged into one 64-bit record: a channel bitmask plus the stamp. The record goes into a first-word-fall-through queue. The queue absorbs bursts, because events may all arrive together while the average rate stays low. A consumer reads the oldest record and pops it. If a record arrives while the queue is full, it is discarded and a sticky overflow flag is set. Only reset clears that flag.

The queue tracks its fill level with three named states:
- `Q_EMPTY` moves to `Q_SOME` on a push. It moves straight to `Q_FULL` when the depth is one.
- `Q_SOME` moves to `Q_FULL` when a push fills the last free slot.
- `Q_SOME` moves to `Q_EMPTY` when a pop removes the last word.
- `Q_FULL` moves back to `Q_SOME` on a pop.
- `Q_FULL` stays put on a push; that push is dropped.

Top module: `osc_stamp_capture`

## Requirements
- R1: While reset is held and after it is released, `empty` is 1 and `overflow` is 0. The time base and every channel prescaler restart from zero, so a prescaler's count does not survive a reset.
- R2: `DIV_RATIO` is even. A channel raises an event on the rising oscillator edges numbered DIV_RATIO/2 + k*DIV_RATIO (k = 0, 1, 2, ...), counted from 1 after reset. No other edge produces an event.
- R3: The record layout is fixed:
  - bits [31:0] hold the channel mask, with bit i set for channel i;
  - bits [32+4*DIGITS-1:32] hold the stamp as BCD digits, with the most significant digit in the highest nibble;
  - all bits above the stamp are 0.
- R4: Let n be the number of reference edges seen since reset release when an event edge arrives, and let it arrive at least a setup time before edge n+1. Then its record carries stamp (n+2) mod 10^DIGITS and can be read after reference edge n+3.
- R5: Events from different channels that fall between the same pair of reference edges share one record. Events in different cycles produce separate records, kept in arrival order.
- R6: Each BCD digit stays in 0..9 and carries into the next digit as it passes 9. The all-nines value is followed by all zeros.
- R7: `rd_data` shows the oldest stored record whenever `empty` is 0. A pop with `empty` = 0 removes that record at the next edge. A pop with `empty` = 1 has no effect.
- R8: A record that arrives while the queue holds `DEPTH` words is dropped, even if a pop happens in the same cycle. The stored words are unchanged, and `overflow` rises at that edge and stays 1 until reset.
- R9: The queue is `Q_FULL` exactly when it holds `DEPTH` words, and `empty` is 1 exactly in `Q_EMPTY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock (10 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| osc_in | input | NUM_CH | Raw oscillator lines, one per channel |
| pop | input | 1 | Remove the oldest record |
| rd_data | output | 64 | Oldest stored record |
| empty | output | 1 | Queue holds no record |
| overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
An event edge arriving after reference edge n has its record visible after edge n+3, stamped n+2. A pop takes effect at the next edge, and `overflow` rises at the edge of the dropped push. The bench drives oscillator lines and `pop` on falling reference edges. It also samples every output on falling edges, so each of these latencies lands on a fixed half-cycle. The driver computes each expected record from its own edge count at the moment it drives the edge. A monitor compares the queue head whenever `empty` is 0, and pops as it compares.

// File: rtl/osc_stamp_pkg.sv
package osc_stamp_pkg;

    localparam int WORD_W = 64;
    localparam int MASK_W = 32;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_SOME  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

endpackage

// File: rtl/osc_prescale.sv
module osc_prescale #(
    parameter int DIV_RATIO = 10_000_000
) (
    input  logic osc,
    input  logic rst_n,
    output logic flag
);
    localparam int HALF  = DIV_RATIO / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge osc or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (cnt == CNT_W'(HALF - 1)) begin
            cnt  <= '0;
            flag <= ~flag;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/osc_sync_rise.sv
module osc_sync_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;

    // R2: one event per rising flag edge, never two cycles in a row
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/bcd_time_base.sv
module bcd_time_base #(
    parameter int DIGITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [4*DIGITS-1:0]   stamp
);
    localparam int W = 4 * DIGITS;
    localparam logic [W-1:0] ALL_NINE = {DIGITS{4'd9}};

    logic [DIGITS:0] carry;

    assign carry[0] = 1'b1;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [3:0] dig;

        assign carry[d+1] = carry[d] & (dig == 4'd9);
        assign stamp[4*d +: 4] = dig;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig <= 4'd0;
            end else if (carry[d]) begin
                dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
            end
        end

        // R6: a digit never leaves the decimal range
        a_r6_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            dig <= 4'd9);
    end

    // R6: all nines is followed by all zeros
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp == ALL_NINE) |=> (stamp == '0));

endmodule

// File: rtl/stamp_fifo.sv
module stamp_fifo
    import osc_stamp_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    q_state_e         state, state_nxt;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign do_push = push && (state != Q_FULL);
    assign do_pop  = pop  && (state != Q_EMPTY);

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: if (do_push) state_nxt = (DEPTH == 1) ? Q_FULL : Q_SOME;
            Q_SOME: begin
                if (do_push && !do_pop && count == CNT_W'(DEPTH - 1))
                    state_nxt = Q_FULL;
                else if (do_pop && !do_push && count == CNT_W'(1))
                    state_nxt = Q_EMPTY;
            end
            Q_FULL:  if (do_pop) state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_SOME;
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wptr <= ptr_step(wptr);
            if (do_pop)  rptr <= ptr_step(rptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && state == Q_FULL) overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // outputs
    always_comb begin
        empty = (state == Q_EMPTY);
        rdata = mem[rptr];
    end

    // R8: the flag never falls outside reset
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R8: a push into a full queue raises the flag
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL && push) |=> overflow);
    // R9: the full state agrees with the word count
    a_r9_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) |-> (count == CNT_W'(DEPTH)));
    // R7: a lone pop removes exactly one word
    a_r7_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/osc_stamp_capture.sv
module osc_stamp_capture
    import osc_stamp_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int DIV_RATIO = 10_000_000,
    parameter int DIGITS    = 7,
    parameter int DEPTH     = 16
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] osc_in,
    input  logic              pop,
    output logic [63:0]       rd_data,
    output logic              empty,
    output logic              overflow
);
    localparam int STAMP_W = 4 * DIGITS;
    localparam int TOP_LSB = MASK_W + STAMP_W;

    logic [NUM_CH-1:0]  flag;
    logic [NUM_CH-1:0]  ev_mask;
    logic [STAMP_W-1:0] stamp;
    logic [WORD_W-1:0]  word;
    logic               push;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        osc_prescale #(.DIV_RATIO(DIV_RATIO)) u_div (
            .osc   (osc_in[c]),
            .rst_n (rst_n),
            .flag  (flag[c])
        );
        osc_sync_rise u_sync (
            .clk      (clk_ref),
            .rst_n    (rst_n),
            .async_in (flag[c]),
            .rise     (ev_mask[c])
        );
    end

    bcd_time_base #(.DIGITS(DIGITS)) u_time (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .stamp (stamp)
    );

    always_comb begin
        word = '0;
        word[NUM_CH-1:0]         = ev_mask;
        word[MASK_W +: STAMP_W]  = stamp;
        push = |ev_mask;
    end

    stamp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    (word),
        .pop      (pop),
        .rdata    (rd_data),
        .empty    (empty),
        .overflow (overflow)
    );

    // R5: every stored record names at least one channel
    a_r5_mask_nonzero: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !empty |-> (rd_data[MASK_W-1:0] != '0));

    if (TOP_LSB < WORD_W) begin : g_pad_chk
        // R3: bits above the stamp are zero at the read side
        a_r3_upper_zero: assert property (@(posedge clk_ref) disable iff (!rst_n)
            !empty |-> (rd_data[WORD_W-1:TOP_LSB] == '0));
    end

endmodule

// File: tb/osc_stamp_capture_tb_top.sv
`timescale 1ns/1ps
module osc_stamp_capture_tb_top;

    localparam int NCH   = 32;
    localparam int DIV   = 4;
    localparam int DIG   = 3;
    localparam int DEPTH = 4;
    localparam int MODV  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] osc = '0;
    logic        pop = 1'b0;
    logic [63:0] rd_data;
    logic        empty, overflow;

    int          errors = 0;
    int          checks = 0;
    int          ncyc = 0;
    int          ecnt [NCH];
    logic [63:0] expq [$];
    logic [63:0] expv;
    logic        drain_en = 1'b1;
    logic        force_pop = 1'b0;

    always #2 clk = ~clk;

    osc_stamp_capture #(
        .NUM_CH(NCH), .DIV_RATIO(DIV), .DIGITS(DIG), .DEPTH(DEPTH)
    ) dut_i (
        .clk_ref (clk), .rst_n (rst_n), .osc_in (osc), .pop (pop),
        .rd_data (rd_data), .empty (empty), .overflow (overflow)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ncyc <= 0;
        else        ncyc <= (ncyc + 1) % MODV;
    end

    function automatic logic [63:0] mk_word(input int v, input logic [31:0] m);
        logic [63:0] w;
        int          s;
        s = v % MODV;
        w = '0;
        w[31:0]  = m;
        w[35:32] = 4'(s % 10);
        w[39:36] = 4'((s / 10) % 10);
        w[43:40] = 4'(s / 100);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: call at a falling edge; returns at the next falling edge
    task automatic osc_drive(input logic [31:0] m);
        logic [31:0] ev;
        ev = '0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i] && !osc[i]) begin
                ecnt[i]++;
                if (ecnt[i] % DIV == DIV / 2) ev[i] = 1'b1;
            end
        end
        osc = m;
        if (ev != '0 && (drain_en || expq.size() < DEPTH))
            expq.push_back(mk_word(ncyc + 2, ev));
        @(negedge clk);
    endtask

    task automatic pulse(input logic [31:0] m);
        osc_drive(m);
        osc_drive('0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain_done(input string tag);
        idle(12);
        chk({tag, " queue drained"}, 64'(expq.size()), 64'd0);
        chk({tag, " empty"}, 64'(empty), 64'd1);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            pop = 1'b0;
        end else begin
            if (drain_en && !empty) begin
                if (expq.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 R5 unexpected record actual=%h expected=none", rd_data);
                end else begin
                    expv = expq.pop_front();
                    chk("R3 R4 R5 R6 record", rd_data, expv);
                end
            end
            pop = (drain_en && !empty) || force_pop;
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) ecnt[i] = 0;
        idle(3);
        chk("R1 reset empty", 64'(empty), 64'd1);
        chk("R1 reset overflow", 64'(overflow), 64'd0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 released empty", 64'(empty), 64'd1);

        // R2: channel 0, event on 2nd then 6th edge
        pulse(32'h1);
        idle(6);
        chk("R2 no event on first edge", 64'(empty), 64'd1);
        pulse(32'h1);
        for (int k = 0; k < 4; k++) pulse(32'h1);
        drain_done("R2");

        // R5: merged channels 1, 2, 31
        pulse(32'h8000_0006);
        pulse(32'h8000_0006);
        drain_done("R5 merge");

        // R5: separate cycles, order kept
        pulse(32'h18);
        pulse(32'h08);
        pulse(32'h10);
        drain_done("R5 order");

        // R6: stamps 999 and 000 across the wrap
        pulse(32'hC0);
        while (ncyc != 997) @(negedge clk);
        osc_drive(32'h40);
        osc_drive(32'h80);
        osc_drive('0);
        drain_done("R6 wrap");

        // R7: pop on empty has no effect
        force_pop = 1'b1;
        idle(4);
        chk("R7 pop on empty", 64'(empty), 64'd1);
        force_pop = 1'b0;
        idle(2);
        pulse(32'h800);
        pulse(32'h800);
        drain_done("R7 after idle pop");

        // R8 / R9: fill, then overflow
        drain_en = 1'b0;
        idle(3);
        for (int k = 0; k < 14; k++) pulse(32'h200);
        idle(5);
        chk("R9 full not empty", 64'(empty), 64'd0);
        chk("R8 full without drop", 64'(overflow), 64'd0);
        for (int k = 0; k < 8; k++) pulse(32'h200);
        idle(5);
        chk("R8 overflow set", 64'(overflow), 64'd1);
        drain_en = 1'b1;
        drain_done("R8 kept words");
        chk("R8 overflow sticky", 64'(overflow), 64'd1);

        // R1: reset clears overflow and prescalers
        pulse(32'h400);
        rst_n = 1'b0;
        osc = '0;
        for (int i = 0; i < NCH; i++) ecnt[i] = 0;
        expq.delete();
        idle(2);
        chk("R1 reset clears overflow", 64'(overflow), 64'd0);
        chk("R1 reset empties queue", 64'(empty), 64'd1);
        rst_n = 1'b1;
        idle(2);
        pulse(32'h400);
        idle(6);
        chk("R1 prescaler restarted", 64'(empty), 64'd1);
        pulse(32'h400);
        drain_done("R1 restart event");

        // R5: all channels at once
        pulse(32'hFFFF_FFFF);
        pulse(32'hFFFF_FFFF);
        drain_done("R5 all channels");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule